// File: doc/BRIEF.md
# Chained-Descriptor Transmit DMA

This block feeds a MAC transmit byte stream from frames held in memory. Software builds four-word descriptors in memory. Each descriptor carries an ownership flag, a control word, a buffer address and a link address. Software then writes the list base address and issues a start command.

The engine reads a descriptor and checks that it owns it. It then reads the buffer one 32-bit word at a time and sends the bytes out on a byte stream with a last flag. When the buffer is done it writes the first descriptor word back with ownership returned to software, and moves on to the next descriptor.

When the engine meets a descriptor it does not own, it parks in a suspended state without touching that buffer. A later poll-demand command makes it read the same descriptor again. A flush command abandons the frame being streamed and reports the abandonment in the written-back status.

Top module: `txdma_engine`

## Requirements
- R1: After reset the state field reads 0 (stopped), no memory request is raised and the stream carries no valid byte.
- R2: The control write's bit 30 (start) only acts in the stopped state, where it begins fetching at the list base. Bit 31 (poll demand) only acts in the suspended state. In any other state each of these bits has no effect.
- R3: A descriptor is read as four words at offsets 0, 4, 8 and 12. If word 0 bit 31 is 0, the engine enters state 6 (suspended) straight after reading word 0. It then reads no buffer word, writes nothing and sends no byte.
- R4: The buffer address is word 2 and the byte count is word 1 bits 10:0. Bytes leave least significant byte first, and the final word is trimmed so that exactly the byte count is sent.
- R5: The last flag is raised only on the final byte of a descriptor whose word 1 bit 30 (last segment) is set. A descriptor with a byte count of 0 sends no bytes.
- R6: A normally completed descriptor gets word 0 written back as 0: ownership (bit 31) is cleared and every status bit is 0.
- R7: The next descriptor address is chosen in this order of priority:
  - word 3, when word 1 bit 24 (chained) is set;
  - the list base, when word 1 bit 25 (end of ring) is set;
  - otherwise the current address plus 16.
- R8: A flush request (control write with bit 0 set) while buffer bytes are still pending stops the byte output at once. The engine then writes word 0 back with bit 15 (error summary) and bit 13 (frame flushed) set and bit 31 clear, and carries on with the next descriptor.
- R9: A flush request has no effect if it comes in the same cycle as the acceptance of the descriptor's final byte, or at any time outside the data phase.
- R10: The state field reads 1 while fetching, 3 while moving buffer data, 7 while writing status back, 6 when suspended and 0 when stopped.
- R11: While a byte is offered and not accepted, the byte and its last flag hold steady.
- R12: A memory request holds its address, direction and write data until it is acknowledged. The only exception is a request dropped by a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr | input | 1 | Write strobe for the list base address |
| base_wdata | input | 32 | List base address (word aligned) |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word: bit 31 poll, bit 30 start, bit 0 flush |
| dma_state | output | 3 | Engine state field |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_tdata | output | 8 | Stream byte |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream byte accepted |
| tx_tlast | output | 1 | Final byte of a frame |

## Verification
Two functions can land in one cycle: a flush command and the acceptance of a descriptor's final byte. The bench provokes this with a single-byte frame. It holds the stream's ready low until the byte is offered, then raises ready and writes the flush in the same cycle. The correct result is a delivered byte carrying the last flag and a written-back word of 0 with no flushed status. A separate case flushes a frame that is stalled mid-buffer and expects the byte output to stop at once and the flushed status to be written back.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_FETCH = 3'd1,
        ST_READ  = 3'd3,
        ST_SUSP  = 3'd6,
        ST_CLOSE = 3'd7
    } dma_st_e;

    localparam int OWN_BIT    = 31;
    localparam int CNT_W      = 11;
    localparam int CHAIN_BIT  = 24;
    localparam int RING_BIT   = 25;
    localparam int LAST_BIT   = 30;
    localparam int ES_BIT     = 15;
    localparam int FF_BIT     = 13;
    localparam int START_BIT  = 30;
    localparam int POLL_BIT   = 31;
    localparam int FLUSH_BIT  = 0;
    localparam int DESC_BYTES = 16;
endpackage

// File: rtl/txdma_cmd_dec.sv
module txdma_cmd_dec
    import txdma_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  dma_st_e          st,
    output logic             start_go,
    output logic             poll_go,
    output logic             flush_go
);
    // Each command is honoured only in the state it applies to.
    always_comb begin
        start_go = ctl_wr && ctl_wdata[START_BIT] && (st == ST_STOP);
        poll_go  = ctl_wr && ctl_wdata[POLL_BIT]  && (st == ST_SUSP);
        flush_go = ctl_wr && ctl_wdata[FLUSH_BIT] && (st == ST_READ);
    end
endmodule

// File: rtl/txdma_next_ptr.sv
module txdma_next_ptr
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] link,
    input  logic              chained,
    input  logic              ring_end,
    output logic [ADDR_W-1:0] nxt
);
    // Chain link wins over end of ring, which wins over the next slot.
    always_comb begin
        if (chained)       nxt = link;
        else if (ring_end) nxt = base;
        else               nxt = cur + ADDR_W'(DESC_BYTES);
    end
endmodule

// File: rtl/txdma_byte_ser.sv
module txdma_byte_ser #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [$clog2(DATA_W/BYTE_W+1)-1:0] load_n,
    input  logic              load_end,
    input  logic              drop,
    input  logic              tready,
    output logic [BYTE_W-1:0] tdata,
    output logic              tvalid,
    output logic              tlast,
    output logic              busy,
    output logic              final_take
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int LW    = $clog2(LANES + 1);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [LW-1:0]     cnt;
        logic              fin;
    } ser_s;

    ser_s q, d;
    logic take;

    assign tvalid     = (q.cnt != '0);
    assign tdata      = q.word[BYTE_W-1:0];
    assign tlast      = q.fin && (q.cnt == LW'(1));
    assign busy       = tvalid;
    assign take       = tvalid && tready;
    assign final_take = take && (q.cnt == LW'(1));

    always_comb begin
        d = q;
        if (drop) begin
            d.cnt = '0;
        end else if (load) begin
            d.word = load_word;
            d.cnt  = load_n;
            d.fin  = load_end;
        end else if (take) begin
            d.word = q.word >> BYTE_W;
            d.cnt  = q.cnt - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R11: an offered byte stays put until taken (a flush may withdraw it)
    p_hold_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && !tready && !drop) |=> (tvalid && $stable(tdata) && $stable(tlast)));

    // R4: a new word is only loaded once the previous one is fully sent
    p_load_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !tvalid);
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [2:0]        dma_state,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_tdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic              tx_tlast
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int LW    = $clog2(LANES + 1);
    localparam int WSTEP = DATA_W / 8;

    typedef struct packed {
        dma_st_e           st;
        logic [1:0]        idx;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] bufp;
        logic [ADDR_W-1:0] link;
        logic [CNT_W-1:0]  left;
        logic              chain;
        logic              ring;
        logic              last_seg;
        logic              emit;
        logic              flushed;
    } eng_s;

    eng_s q, d;

    logic              start_go, poll_go, flush_go;
    logic [ADDR_W-1:0] nxt_desc;
    logic              ser_load, ser_drop, ser_busy, ser_final;
    logic [LW-1:0]     nb;
    logic              nb_end;
    logic              done_now, abort;

    txdma_cmd_dec #(.CTL_W(DATA_W)) u_cmd (
        .ctl_wr   (ctl_wr),
        .ctl_wdata(ctl_wdata),
        .st       (q.st),
        .start_go (start_go),
        .poll_go  (poll_go),
        .flush_go (flush_go)
    );

    txdma_next_ptr #(.ADDR_W(ADDR_W)) u_nxt (
        .cur     (q.cur),
        .base    (q.base),
        .link    (q.link),
        .chained (q.chain),
        .ring_end(q.ring),
        .nxt     (nxt_desc)
    );

    txdma_byte_ser #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ser_load),
        .load_word (mem_rdata),
        .load_n    (nb),
        .load_end  (nb_end),
        .drop      (ser_drop),
        .tready    (tx_tready),
        .tdata     (tx_tdata),
        .tvalid    (tx_tvalid),
        .tlast     (tx_tlast),
        .busy      (ser_busy),
        .final_take(ser_final)
    );

    assign dma_state = q.st;
    assign nb        = (q.left >= CNT_W'(LANES)) ? LW'(LANES) : LW'(q.left);
    assign nb_end    = (q.left <= CNT_W'(LANES)) && q.last_seg;
    // all bytes of this descriptor are delivered now or already
    assign done_now  = q.emit && (q.left == '0) && (ser_final || !ser_busy);

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ser_load  = 1'b0;
        ser_drop  = 1'b0;
        abort     = 1'b0;
        if (base_wr) d.base = {base_wdata[ADDR_W-1:2], 2'b00};
        case (q.st)
            ST_STOP: if (start_go) begin
                d.st  = ST_FETCH;
                d.cur = q.base;
                d.idx = '0;
            end
            ST_SUSP: if (poll_go) begin
                d.st  = ST_FETCH;
                d.idx = '0;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + ADDR_W'({q.idx, 2'b00});
                if (mem_ack) begin
                    d.idx = q.idx + 2'd1;
                    case (q.idx)
                        2'd0: if (!mem_rdata[OWN_BIT]) d.st = ST_SUSP;
                        2'd1: begin
                            d.left     = mem_rdata[CNT_W-1:0];
                            d.chain    = mem_rdata[CHAIN_BIT];
                            d.ring     = mem_rdata[RING_BIT];
                            d.last_seg = mem_rdata[LAST_BIT];
                        end
                        2'd2: d.bufp = {mem_rdata[ADDR_W-1:2], 2'b00};
                        default: begin
                            d.link = {mem_rdata[ADDR_W-1:2], 2'b00};
                            d.emit = 1'b0;
                            d.st   = (q.left == '0) ? ST_CLOSE : ST_READ;
                        end
                    endcase
                end
            end
            ST_READ: begin
                if (flush_go && !done_now) begin
                    abort     = 1'b1;
                    ser_drop  = 1'b1;
                    d.flushed = 1'b1;
                    d.st      = ST_CLOSE;
                end else if (!q.emit) begin
                    mem_req  = 1'b1;
                    mem_addr = q.bufp;
                    if (mem_ack) begin
                        ser_load = 1'b1;
                        d.left   = q.left - CNT_W'(nb);
                        d.bufp   = q.bufp + ADDR_W'(WSTEP);
                        d.emit   = 1'b1;
                    end
                end else if (!ser_busy) begin
                    if (q.left == '0) d.st = ST_CLOSE;
                    else              d.emit = 1'b0;
                end
            end
            ST_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur;
                mem_wdata[ES_BIT] = q.flushed;
                mem_wdata[FF_BIT] = q.flushed;
                if (mem_ack) begin
                    d.cur     = nxt_desc;
                    d.flushed = 1'b0;
                    d.idx     = '0;
                    d.st      = ST_FETCH;
                end
            end
            default: d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R12: an outstanding request is held until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6: every write-back hands the descriptor back to software
    p_wb_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R8: flushed flag and error summary always travel together
    p_flush_es_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[ES_BIT] == mem_wdata[FF_BIT]));

    // R3: an unowned word 0 parks the engine
    p_unowned_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && q.idx == 2'd0 && mem_ack && !mem_rdata[OWN_BIT])
        |=> (dma_state == 3'd6));

    // R5: last flag only for a last-segment descriptor
    p_tlast_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tvalid && tx_tlast) |-> q.last_seg);

    // R2: leaving the stopped state only goes to fetching
    p_stop_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_state == 3'd0) |=> (dma_state == 3'd0 || dma_state == 3'd1));
endmodule

// File: tb/txdma_engine_tb.sv
module txdma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [2:0]  dma_state;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  tx_tdata;
    logic        tx_tvalid, tx_tlast;
    logic        tx_tready = 1'b1;

    localparam logic [31:0] OWN   = 32'h8000_0000;
    localparam logic [31:0] LASTS = 32'h4000_0000;
    localparam logic [31:0] FIRST = 32'h2000_0000;
    localparam logic [31:0] RING  = 32'h0200_0000;
    localparam logic [31:0] CHAIN = 32'h0100_0000;

    always #4 clk = ~clk;

    txdma_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .base_wr(base_wr), .base_wdata(base_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dma_state(dma_state),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid),
        .tx_tready(tx_tready), .tx_tlast(tx_tlast)
    );

    logic [31:0] mem [0:511];
    int          lat = 0;
    int          wc = 0;
    logic        rdy_force = 1'b1;
    logic        rdy_mode = 1'b0;
    logic [7:0]  cap [0:63];
    logic        cap_l [0:63];
    int          cap_n = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    // memory and stream sink act at the falling edge
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wc = 0;
        end else if (mem_req) begin
            if (wc >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr[10:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[10:2]];
            end else begin
                wc++;
            end
        end
        if (rdy_mode) tx_tready = ~tx_tready;
        else          tx_tready = rdy_force;
        if (tx_tvalid && tx_tready && cap_n < 64) begin
            cap[cap_n]   = tx_tdata;
            cap_l[cap_n] = tx_tlast;
            cap_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic ctl_write(input logic [31:0] v);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        tick(1);
        ctl_wr = 1'b0;
        ctl_wdata = '0;
    endtask

    task automatic set_desc(input int a, input logic [31:0] w0, w1, w2, w3);
        mem[a >> 2]       = w0;
        mem[(a >> 2) + 1] = w1;
        mem[(a >> 2) + 2] = w2;
        mem[(a >> 2) + 3] = w3;
    endtask

    task automatic wait_susp(input string req);
        for (int i = 0; i < 3000 && dma_state != 3'd6; i++) tick(1);
        chk(req, {29'd0, dma_state}, 32'd6);
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 300 && !tx_tvalid; i++) tick(1);
    endtask

    // compare captured bytes from index c0 against buffer b, n bytes
    task automatic chk_bytes(input string req, input int c0, input int b, input int n, input bit lastx);
        for (int k = 0; k < n; k++) begin
            logic [31:0] w;
            w = mem[(b >> 2) + k / 4];
            chk(req, {24'd0, cap[c0 + k]}, {24'd0, w[(k % 4) * 8 +: 8]});
            chk(req, {31'd0, cap_l[c0 + k]}, {31'd0, (lastx && k == n - 1)});
        end
    endtask

    task automatic t_reset();
        chk("R1 state", {29'd0, dma_state}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 tvalid", {31'd0, tx_tvalid}, 32'd0);
    endtask

    task automatic t_poll_stopped();
        ctl_write(OWN);
        tick(5);
        chk("R2 poll ignored when stopped", {29'd0, dma_state}, 32'd0);
        chk("R2 no request", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_single();
        set_desc(32'h100, OWN, LASTS | FIRST | CHAIN | 32'd7, 32'h200, 32'h140);
        set_desc(32'h140, 32'h0000_1234, 32'h0, 32'h0, 32'h0);
        mem[32'h200 >> 2] = 32'h4433_2211;
        mem[32'h204 >> 2] = 32'h8877_6655;
        base_wr = 1'b1; base_wdata = 32'h100;
        tick(1);
        base_wr = 1'b0;
        cap_n = 0;
        ctl_write(LASTS);
        chk("R10 fetching code", {29'd0, dma_state}, 32'd1);
        wait_susp("R3 suspend on unowned");
        chk("R4 byte count", cap_n, 32'd7);
        chk_bytes("R4/R5 single frame", 0, 32'h200, 7, 1'b1);
        chk("R6 word0 written back", mem[32'h100 >> 2], 32'h0);
        chk("R3 unowned not written", mem[32'h140 >> 2], 32'h0000_1234);
    endtask

    task automatic t_ignored_in_susp();
        int c;
        c = cap_n;
        ctl_write(LASTS | 32'd1);
        tick(6);
        chk("R2 start ignored when suspended", {29'd0, dma_state}, 32'd6);
        chk("R9 flush ignored when suspended", {31'd0, mem_req}, 32'd0);
        chk("R3 no output while suspended", cap_n, c);
    endtask

    task automatic t_ring_wrap();
        set_desc(32'h140, OWN, LASTS | RING | 32'd5, 32'h300, 32'hDEAD_0000);
        mem[32'h300 >> 2] = 32'hD4C3_B2A1;
        mem[32'h304 >> 2] = 32'h0000_00E5;
        cap_n = 0;
        ctl_write(OWN);
        wait_susp("R2 poll resumes");
        chk("R4 count 5", cap_n, 32'd5);
        chk_bytes("R4 ring frame", 0, 32'h300, 5, 1'b1);
        chk("R6 wb at 0x140", mem[32'h140 >> 2], 32'h0);
    endtask

    task automatic t_sequential();
        // engine parked at list base after wrap; next-slot then wrap
        set_desc(32'h100, OWN, LASTS | 32'd3, 32'h400, 32'h0);
        set_desc(32'h110, OWN, LASTS | RING | 32'd2, 32'h440, 32'h0);
        mem[32'h400 >> 2] = 32'h0033_2211;
        mem[32'h440 >> 2] = 32'h0000_BBAA;
        lat = 2;
        rdy_mode = 1'b1;
        cap_n = 0;
        ctl_write(OWN);
        wait_susp("R7 wrap returns to base");
        rdy_mode = 1'b0;
        lat = 0;
        chk("R7 next slot bytes", cap_n, 32'd5);
        chk_bytes("R7 first slot", 0, 32'h400, 3, 1'b1);
        chk_bytes("R7 plus 16 slot", 3, 32'h440, 2, 1'b1);
        chk("R6 wb 0x110", mem[32'h110 >> 2], 32'h0);
    endtask

    task automatic t_multiseg();
        set_desc(32'h100, OWN, FIRST | CHAIN | 32'd2, 32'h500, 32'h120);
        set_desc(32'h120, OWN, CHAIN, 32'h520, 32'h130);
        set_desc(32'h130, OWN, LASTS | CHAIN | 32'd3, 32'h540, 32'h100);
        mem[32'h500 >> 2] = 32'h0000_0201;
        mem[32'h540 >> 2] = 32'h0005_0403;
        cap_n = 0;
        ctl_write(OWN);
        wait_susp("R5 multi-segment done");
        chk("R5 total bytes", cap_n, 32'd5);
        chk_bytes("R5 no last mid-frame", 0, 32'h500, 2, 1'b0);
        chk_bytes("R5 last on final seg", 2, 32'h540, 3, 1'b1);
        chk("R5 zero-length wb", mem[32'h120 >> 2], 32'h0);
        chk("R6 wb 0x130", mem[32'h130 >> 2], 32'h0);
    endtask

    task automatic t_flush_mid();
        set_desc(32'h100, OWN, LASTS | CHAIN | 32'd12, 32'h600, 32'h100);
        mem[32'h600 >> 2] = 32'h1111_1111;
        cap_n = 0;
        rdy_force = 1'b0;
        ctl_write(OWN);
        wait_valid();
        tick(2);
        chk("R10 reading code", {29'd0, dma_state}, 32'd3);
        ctl_write(32'd1);
        chk("R8 output stops", {31'd0, tx_tvalid}, 32'd0);
        rdy_force = 1'b1;
        wait_susp("R8 continues to next");
        chk("R8 no bytes", cap_n, 32'd0);
        chk("R8 flushed status", mem[32'h100 >> 2], 32'h0000_A000);
    endtask

    task automatic t_flush_race();
        set_desc(32'h100, OWN, LASTS | CHAIN | 32'd1, 32'h700, 32'h100);
        mem[32'h700 >> 2] = 32'hFFFF_FFAB;
        cap_n = 0;
        rdy_force = 1'b0;
        ctl_write(OWN);
        wait_valid();
        rdy_force = 1'b1;
        ctl_write(32'd1);
        wait_susp("R9 race completes");
        chk("R9 byte delivered", cap_n, 32'd1);
        chk("R9 byte value", {24'd0, cap[0]}, 32'h0000_00AB);
        chk("R9 last flag", {31'd0, cap_l[0]}, 32'd1);
        chk("R9 clean status", mem[32'h100 >> 2], 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_poll_stopped();
        t_single();
        t_ignored_in_susp();
        t_ring_wrap();
        t_sequential();
        t_multiseg();
        t_flush_mid();
        t_flush_race();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule